// File: doc/BRIEF.md
# Dual-Phase Bit-Rate Enable Generator

This block turns one programmable 8-bit auto-reload timer into two bit-rate enables for an asynchronous serial port: one for the transmitter and one for the receiver. A source selector picks what advances the timer. The choices are the system clock, three fixed prescales of it, an external oscillator tick divided by eight, or rising edges of an external count pin. Every source reaches the counters as a single-cycle count strobe in the system clock domain. The counters never see a derived clock.

Two counters share one reload byte. The transmit counter runs freely. The receive counter is a private copy that nothing outside the block can read or write. Each counter counts up and, after its all-ones state, reloads from the reload byte. Its overflow rate is therefore tick / (256 − reload). A toggle stage halves each overflow stream and emits a one-cycle enable on every second overflow.

A start-detect pulse on the receive side forces the receive counter to reload and clears its toggle stage. This puts receive sampling at a fixed distance from the start edge, whatever phase the transmit side is in. The serial shifters and framing sit outside this block.

Top module: `baud_gen_dual`

## Requirements
- R1: After reset both `tx_bit_en_o` and `rx_bit_en_o` are low. They stay low until the first enable is due.
- R2: While enabled with a fixed source and reload value R, `tx_bit_en_o` is a one-cycle pulse. Consecutive pulses are 2·(256 − R) source ticks apart.
- R3: Without start pulses, `rx_bit_en_o` has the same one-cycle form and the same 2·(256 − R) tick spacing as the transmit enable.
- R4: A start pulse sampled while enabled reloads the receive counter and clears its half-rate stage. The first following `rx_bit_en_o` is visible 2·(256 − R) source ticks after the capturing edge, plus one register stage. No receive enable appears before it. The transmit enable spacing is not disturbed.
- R5: `src_sel_i` encoding: 0 selects every system clock cycle, 1 every 4th cycle, 2 every 12th cycle and 3 every 48th cycle. Code 4 selects every 8th `ext_osc_tick_i` strobe. Code 5 selects each rising edge of `ext_cnt_i`, taken after a two-flop synchroniser. Codes 6 and 7 produce no ticks, so no enables appear.
- R6: While `en_i` is low both counters and their half-rate stages hold their values and no enable is produced. After re-enabling, counting resumes from the held state.
- R7: A change of `reload_i` does not disturb the count in progress. The new value is first loaded at the next overflow.
- R8: With reload 0xFF each tick overflows the counter, so with the system clock source the enables pulse every second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| en_i | input | 1 | Timer run enable |
| src_sel_i | input | 3 | Count source select (encoding in R5) |
| reload_i | input | 8 | Shared auto-reload value |
| ext_osc_tick_i | input | 1 | One-cycle strobe from the external oscillator domain, already in the system clock domain |
| ext_cnt_i | input | 1 | Asynchronous external count pin |
| rx_start_i | input | 1 | One-cycle start-condition detect from the receiver |
| tx_bit_en_o | output | 1 | Transmit bit-rate enable pulse |
| rx_bit_en_o | output | 1 | Receive bit-rate enable pulse |

## Verification
The hardest conditions to reach from the ports are the mid-period events: a start pulse landing at an arbitrary point of the receive phase, a disable in the middle of a count, and a reload change between two reloads. The stimulus produces each of them by waiting for an observed transmit enable, which pins the counter state to a known value. It then applies the event after a chosen offset and counts cycles to the next enable.

// File: rtl/bg_pkg.sv
package bg_pkg;

  // Count source selection codes; unlisted codes yield no ticks.
  typedef enum logic [2:0] {
    BG_SRC_SYS    = 3'd0,
    BG_SRC_DIV4   = 3'd1,
    BG_SRC_DIV12  = 3'd2,
    BG_SRC_DIV48  = 3'd3,
    BG_SRC_EXTOSC = 3'd4,
    BG_SRC_PIN    = 3'd5
  } bg_src_e;

  localparam int unsigned BG_NUM_SYS_DIV = 3;

endpackage

// File: rtl/bg_prescale.sv
module bg_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  output logic tick_o
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick_o  = inc_i & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  generate
    if (DIV > 1) begin : g_chk
      // R5: a divided source never strobes on two adjacent cycles
      assert_prescale_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/bg_edge_sync.sv
module bg_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);

  logic [2:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[1:0], pin_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rise_o = sh_q[1] & ~sh_q[2];

  // R5: an edge strobe is one cycle wide
  assert_pin_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/bg_src_sel.sv
module bg_src_sel
  import bg_pkg::*;
#(
  parameter int unsigned DIV_A   = 4,
  parameter int unsigned DIV_B   = 12,
  parameter int unsigned DIV_C   = 48,
  parameter int unsigned DIV_EXT = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       ext_osc_tick_i,
  input  logic       ext_cnt_i,
  output logic       tick_o
);

  logic [BG_NUM_SYS_DIV-1:0] sys_tick;
  logic                      ext_tick;
  logic                      pin_tick;

  for (genvar i = 0; i < BG_NUM_SYS_DIV; i++) begin : g_sys
    localparam int unsigned D = (i == 0) ? DIV_A : (i == 1) ? DIV_B : DIV_C;
    bg_prescale #(.DIV(D)) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (1'b1),
      .tick_o (sys_tick[i])
    );
  end

  bg_prescale #(.DIV(DIV_EXT)) u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ext_osc_tick_i),
    .tick_o (ext_tick)
  );

  bg_edge_sync u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_cnt_i),
    .rise_o (pin_tick)
  );

  always_comb begin
    case (bg_src_e'(sel_i))
      BG_SRC_SYS:    tick_o = 1'b1;
      BG_SRC_DIV4:   tick_o = sys_tick[0];
      BG_SRC_DIV12:  tick_o = sys_tick[1];
      BG_SRC_DIV48:  tick_o = sys_tick[2];
      BG_SRC_EXTOSC: tick_o = ext_tick;
      BG_SRC_PIN:    tick_o = pin_tick;
      default:       tick_o = 1'b0;
    endcase
  end

  // R5: unassigned select codes never advance the timer
  assert_no_tick_unused_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i > 3'd5) |-> !tick_o);

endmodule

// File: rtl/bg_rate_cnt.sv
module bg_rate_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             force_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             bit_en_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             half_q, half_d;
  logic             pulse_q, pulse_d;

  always_comb begin
    cnt_d   = cnt_q;
    half_d  = half_q;
    pulse_d = 1'b0;
    if (en_i) begin
      if (force_i) begin
        cnt_d  = reload_i;
        half_d = 1'b0;
      end else if (tick_i) begin
        if (cnt_q == CNT_MAX) begin
          cnt_d   = reload_i;
          half_d  = ~half_q;
          pulse_d = half_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      half_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      half_q  <= half_d;
      pulse_q <= pulse_d;
    end
  end

  assign bit_en_o = pulse_q;

  // R2: a tick below the top value advances the count by one
  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !force_i && cnt_q != CNT_MAX) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R2: enables are single-cycle pulses
  assert_pulse_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_o |=> !bit_en_o);

  // R7: the overflow reloads whatever value is present at that moment
  assert_reload_on_ovf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !force_i && cnt_q == CNT_MAX) |=> (cnt_q == $past(reload_i)));

  // R6: disabled counters keep their state
  assert_hold_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && $stable(half_q)));

  // R4: a forced reload suppresses any enable on the next cycle
  assert_force_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && force_i) |=> !bit_en_o);

endmodule

// File: rtl/baud_gen_dual.sv
module baud_gen_dual #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned DIV_A   = 4,
  parameter int unsigned DIV_B   = 12,
  parameter int unsigned DIV_C   = 48,
  parameter int unsigned DIV_EXT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [2:0]       src_sel_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             ext_osc_tick_i,
  input  logic             ext_cnt_i,
  input  logic             rx_start_i,
  output logic             tx_bit_en_o,
  output logic             rx_bit_en_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  bg_src_sel #(
    .DIV_A   (DIV_A),
    .DIV_B   (DIV_B),
    .DIV_C   (DIV_C),
    .DIV_EXT (DIV_EXT)
  ) u_src (
    .clk_i          (clk_i),
    .rst_ni         (rst_n),
    .sel_i          (src_sel_i),
    .ext_osc_tick_i (ext_osc_tick_i),
    .ext_cnt_i      (ext_cnt_i),
    .tick_o         (tick)
  );

  bg_rate_cnt #(.CNT_W(CNT_W)) u_tx_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .en_i     (en_i),
    .tick_i   (tick),
    .force_i  (1'b0),
    .reload_i (reload_i),
    .bit_en_o (tx_bit_en_o)
  );

  bg_rate_cnt #(.CNT_W(CNT_W)) u_rx_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .en_i     (en_i),
    .tick_i   (tick),
    .force_i  (rx_start_i),
    .reload_i (reload_i),
    .bit_en_o (rx_bit_en_o)
  );

  // R6: a cycle with the timer off is followed by no enable on either side
  assert_off_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> (!tx_bit_en_o && !rx_bit_en_o));

  // R1: both enables are low while the internal reset is held
  always_comb begin
    if (!rst_n) assert_reset_low_R1: assert (!tx_bit_en_o && !rx_bit_en_o);
  end

endmodule

// File: tb/baud_gen_dual_tb.sv
module baud_gen_dual_tb;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       en;
  logic [2:0] src_sel;
  logic [7:0] reload;
  logic       ext_osc_tick;
  logic       ext_cnt;
  logic       rx_start;
  logic       tx_en;
  logic       rx_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int    exp_tx_q[$];
  string tag_tx_q[$];
  int    exp_rx_q[$];
  string tag_rx_q[$];

  int tx_gap = 0;
  int rx_gap = 0;
  bit tx_seen = 1'b0;
  bit rx_seen = 1'b0;

  always #2 clk = ~clk;

  baud_gen_dual u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .en_i           (en),
    .src_sel_i      (src_sel),
    .reload_i       (reload),
    .ext_osc_tick_i (ext_osc_tick),
    .ext_cnt_i      (ext_cnt),
    .rx_start_i     (rx_start),
    .tx_bit_en_o    (tx_en),
    .rx_bit_en_o    (rx_en)
  );

  task automatic check_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // External oscillator strobe every 3rd cycle; count pin period of 10 cycles.
  initial begin
    ext_osc_tick = 1'b0;
    forever begin
      repeat (2) @(negedge clk);
      ext_osc_tick = 1'b1;
      @(negedge clk);
      ext_osc_tick = 1'b0;
    end
  end

  initial begin
    ext_cnt = 1'b0;
    forever begin
      repeat (5) @(negedge clk);
      ext_cnt = ~ext_cnt;
    end
  end

  // Monitor: measures gaps between enables and compares against the scoreboard.
  always @(negedge clk) begin
    if (!rst_ni) begin
      tx_gap = 0; rx_gap = 0; tx_seen = 1'b0; rx_seen = 1'b0;
    end else begin
      tx_gap++;
      rx_gap++;
      if (tx_en) begin
        if (tx_seen && exp_tx_q.size() > 0)
          check_int(tag_tx_q.pop_front(), tx_gap, exp_tx_q.pop_front());
        tx_seen = 1'b1;
        tx_gap  = 0;
      end
      if (rx_en) begin
        if (rx_seen && exp_rx_q.size() > 0)
          check_int(tag_rx_q.pop_front(), rx_gap, exp_rx_q.pop_front());
        rx_seen = 1'b1;
        rx_gap  = 0;
      end
    end
  end

  // Driver: configure, let both sides settle, then push expected gaps.
  task automatic run_period(logic [2:0] sel, logic [7:0] rl, int gap, string tx_tag, string rx_tag);
    int ntx = 0;
    int nrx = 0;
    @(negedge clk);
    src_sel = sel;
    reload  = rl;
    en      = 1'b1;
    while (ntx < 3 || nrx < 3) begin
      @(negedge clk);
      if (tx_en) ntx++;
      if (rx_en) nrx++;
    end
    for (int i = 0; i < 2; i++) begin
      exp_tx_q.push_back(gap); tag_tx_q.push_back(tx_tag);
      exp_rx_q.push_back(gap); tag_rx_q.push_back(rx_tag);
    end
    while (exp_tx_q.size() > 0 || exp_rx_q.size() > 0) @(negedge clk);
  endtask

  task automatic wait_tx_pulse();
    @(negedge clk);
    while (!tx_en) @(negedge clk);
  endtask

  // R4: start pulse after a given offset from a transmit enable.
  task automatic start_realign(int offset, int n_ticks, string tag);
    int first_k = 0;
    int tx_gap_seen = 0;
    wait_tx_pulse();
    repeat (offset) @(negedge clk);
    rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
    for (int k = 1; k <= 2 * n_ticks + 8; k++) begin
      if (rx_en && first_k == 0) first_k = k;
      @(negedge clk);
    end
    check_int(tag, first_k, 2 * n_ticks + 1);
    // Transmit side keeps its own spacing (R4): measure one full gap.
    wait_tx_pulse();
    tx_gap_seen = 0;
    @(negedge clk);
    tx_gap_seen = 1;
    while (!tx_en) begin @(negedge clk); tx_gap_seen++; end
    check_int("R4 tx spacing undisturbed by start", tx_gap_seen, 2 * n_ticks);
  endtask

  initial begin
    int quiet;
    int k;
    rst_ni   = 1'b0;
    en       = 1'b0;
    src_sel  = 3'd0;
    reload   = 8'hF0;
    rx_start = 1'b0;
    repeat (5) @(negedge clk);
    check_int("R1 tx enable low in reset", int'(tx_en), 0);
    check_int("R1 rx enable low in reset", int'(rx_en), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check_int("R1 tx enable low after reset", int'(tx_en), 0);
    check_int("R1 rx enable low after reset", int'(rx_en), 0);

    // R2 / R3: system clock source, several reload values
    run_period(3'd0, 8'hF0, 32,  "R2 tx sys reload F0", "R3 rx sys reload F0");
    run_period(3'd0, 8'h00, 512, "R2 tx sys reload 00", "R3 rx sys reload 00");
    // R8: reload 0xFF boundary
    run_period(3'd0, 8'hFF, 2,   "R8 tx sys reload FF", "R8 rx sys reload FF");
    // R5: each source
    run_period(3'd1, 8'hFC, 32,  "R5 tx div4",   "R5 rx div4");
    run_period(3'd2, 8'hFD, 72,  "R5 tx div12",  "R5 rx div12");
    run_period(3'd3, 8'hFE, 192, "R5 tx div48",  "R5 rx div48");
    run_period(3'd4, 8'hFE, 96,  "R5 tx extosc", "R5 rx extosc");
    run_period(3'd5, 8'hFC, 80,  "R5 tx pin",    "R5 rx pin");

    // R5: unused select codes give no enables
    for (int s = 6; s < 8; s++) begin
      @(negedge clk);
      src_sel = 3'(s);
      repeat (4) @(negedge clk);
      quiet = 0;
      for (int c = 0; c < 600; c++) begin
        @(negedge clk);
        if (tx_en || rx_en) quiet++;
      end
      check_int("R5 unused select yields no enables", quiet, 0);
    end

    // R4: start realignment at two different offsets, sys source reload F0
    run_period(3'd0, 8'hF0, 32, "R2 tx sys reload F0 again", "R3 rx sys reload F0 again");
    start_realign(7,  16, "R4 first rx enable after start, offset 7");
    start_realign(23, 16, "R4 first rx enable after start, offset 23");

    // R6: disable right after a transmit enable, then resume
    wait_tx_pulse();
    en = 1'b0;
    quiet = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (tx_en || rx_en) quiet++;
    end
    check_int("R6 no enables while disabled", quiet, 0);
    en = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!tx_en && k < 1000);
    check_int("R6 resume completes held count", k, 32);

    // R7: reload change just after an enable takes effect at the next reload
    wait_tx_pulse();
    reload = 8'hF8;
    k = 0;
    do begin @(negedge clk); k++; end while (!tx_en && k < 1000);
    check_int("R7 reload change at next reload", k, 16 + 8);
    run_period(3'd0, 8'hF8, 16, "R7 tx new reload steady", "R7 rx new reload steady");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule